// File: doc/BRIEF.md
# Sized Base Address Register with Region Decoder

This block holds one base address register of a peripheral target's configuration space, together with the small command register that gates it and the decoder that claims bus accesses. Software finds out how much address space the target needs by writing all ones into the base register and reading it back. The low address bits are fixed at zero, so the readback shows a mask whose two's complement is the region size. Software then writes a naturally aligned base and sets the matching space-enable bit. From then on every bus access inside the region raises a hit.

The register is reached through a 32-bit configuration port. The port takes a dword offset, a write strobe, four byte enables and a combinational read-data output. Two parameters fix the block: the size of the region as a power of two, and whether it lives in I/O space or in memory space. A slot-absent input models an empty slot. In that state the block answers every configuration read with all ones, ignores every write and claims no access.

Top module: `bar_sizing_top`

## Requirements
- R1: After reset, the base register reads back only its type bits, the command dword at offset 1 reads 0, and no bus access is claimed.
- R2: Bit 0 of the base register (dword offset 4) reads 1 for an I/O region and 0 for a memory region. No write changes it. In a memory region bits 3:0 read 0, and in an I/O region bit 1 reads 0.
- R3: After all ones are written to offset 4, a read returns ones above bit SIZE_LOG2-1, zeros below it, and the type bit. For a 0x1000-byte memory region this is 0xFFFFF000, and for a 0x100-byte I/O region it is 0xFFFFFF01.
- R4: Written data in bits below SIZE_LOG2 is dropped, so the stored base is always aligned to the region size.
- R5: A write updates only the byte lanes whose byte-enable bit is 1. cfg_be[n] covers cfg_wdata[8n+7:8n].
- R6: At dword offset 1, bit 0 is the I/O-space enable and bit 1 is the memory-space enable. Both are written through byte lane 0 and read back in the same positions, with all other bits reading 0.
- R7: No access is claimed unless the enable bit for the access's space is 1.
- R8: bus_hit is 1 exactly when bus_valid is 1, the access space (bus_is_io) matches the region type, that space is enabled, and the address bits at and above SIZE_LOG2 equal those of the base. So base and base+size-1 are claimed, while base-1 and base+size are not.
- R9: While slot_absent is 1, every configuration read returns 0xFFFFFFFF, writes change nothing, and bus_hit stays 0.
- R10: With the slot present, dword offset 0 reads {DEVICE_ID, VENDOR_ID}, with the device identifier in bits 31:16.
- R11: With the slot present, every other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_absent | input | 1 | Models an empty slot |
| cfg_addr | input | ADDR_W | Configuration dword offset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, combinational from cfg_addr |
| bus_valid | input | 1 | A bus access is presented |
| bus_is_io | input | 1 | 1 for an I/O-space access, 0 for a memory-space access |
| bus_addr | input | 32 | Bus access address |
| bus_hit | output | 1 | The access falls in the enabled region |

## Verification
Several properties are checked on every cycle. These are the fixed type bit and the zero low bits of the base readback, the all-ones readback and silence of an absent slot, and that a claim always has the matching enable and space type. Two more are that the base only moves on a present write to its offset, and that both enables are clear right after reset. The sizing value, the alignment of a written base, byte-lane merging, and the exact edges of the claimed window can only be shown by the bench's scenarios. The bench drives these on a memory instance and an I/O instance against its own model.

// File: rtl/bar_pkg.sv
// Shared constants for the sized base address register block.
// Assumes dword offsets within one function's configuration space.
package bar_pkg;
    localparam int unsigned OFF_ID  = 0;
    localparam int unsigned OFF_CMD = 1;
    localparam int unsigned OFF_BAR = 4;

    typedef struct packed {
        logic mem_en;
        logic io_en;
    } space_en_t;
endpackage

// File: rtl/bar_cmd_reg.sv
// Space-enable pair of the command dword.
// Assumes the caller qualifies wr_sel with offset and slot presence.
module bar_cmd_reg
    import bar_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_sel,
    input  logic      be_lo,
    input  logic [1:0] wdata_lo,
    output space_en_t en
);
    // Load both enables from byte lane 0 on a selected write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= '0;
        end else if (wr_sel && be_lo) begin
            en.io_en  <= wdata_lo[0];
            en.mem_en <= wdata_lo[1];
        end
    end
endmodule

// File: rtl/bar_base_reg.sv
// Base field storage with hard-wired low bits.
// Assumes SIZE_LOG2 is in 2..31; bits below SIZE_LOG2 never store a one.
module bar_base_reg #(
    parameter int SIZE_LOG2 = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_sel,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] base
);
    localparam logic [31:0] WMASK = 32'hFFFF_FFFF << SIZE_LOG2;

    logic [31:0] base_q;

    for (genvar b = 0; b < 4; b++) begin : g_lane
        // Update one byte lane of the writable field when its enable is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[b*8 +: 8] <= '0;
            end else if (wr_sel && be[b]) begin
                base_q[b*8 +: 8] <= wdata[b*8 +: 8] & WMASK[b*8 +: 8];
            end
        end
    end

    assign base = base_q;
endmodule

// File: rtl/bar_decode.sv
// Region match for the bus side.
// Assumes base has its low SIZE_LOG2 bits at zero.
module bar_decode
    import bar_pkg::*;
#(
    parameter int SIZE_LOG2 = 12,
    parameter bit IS_IO     = 1'b0
) (
    input  logic [31:0] base,
    input  space_en_t   en,
    input  logic        slot_absent,
    input  logic        bus_valid,
    input  logic        bus_is_io,
    input  logic [31:0] bus_addr,
    output logic        bus_hit
);
    localparam logic [31:0] AMASK = 32'hFFFF_FFFF << SIZE_LOG2;

    logic space_ok;
    logic addr_ok;

    if (IS_IO) begin : g_io
        // I/O region: only I/O accesses with the I/O enable set qualify.
        always_comb space_ok = bus_is_io && en.io_en;
    end else begin : g_mem
        // Memory region: only memory accesses with the memory enable set qualify.
        always_comb space_ok = !bus_is_io && en.mem_en;
    end

    // Compare the address bits above the region size.
    always_comb addr_ok = ((bus_addr ^ base) & AMASK) == 32'h0;

    // Claim the access when all conditions meet.
    always_comb bus_hit = bus_valid && !slot_absent && space_ok && addr_ok;
endmodule

// File: rtl/bar_sizing_top.sv
// Configuration base address register with sizing readback and decoder.
// Assumes SIZE_LOG2 >= 4 for memory regions and >= 2 for I/O regions.
module bar_sizing_top
    import bar_pkg::*;
#(
    parameter int          SIZE_LOG2 = 12,
    parameter bit          IS_IO     = 1'b0,
    parameter int          ADDR_W    = 6,
    parameter logic [15:0] VENDOR_ID = 16'h1F2E,
    parameter logic [15:0] DEVICE_ID = 16'h0A5C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_absent,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr_en,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              bus_valid,
    input  logic              bus_is_io,
    input  logic [31:0]       bus_addr,
    output logic              bus_hit
);
    localparam logic [31:0] TYPE_BITS = IS_IO ? 32'h1 : 32'h0;

    space_en_t   en;
    logic [31:0] base;
    logic        wr_cmd;
    logic        wr_bar;

    // Qualify writes by offset and slot presence.
    always_comb begin
        wr_cmd = cfg_wr_en && !slot_absent && (cfg_addr == ADDR_W'(OFF_CMD));
        wr_bar = cfg_wr_en && !slot_absent && (cfg_addr == ADDR_W'(OFF_BAR));
    end

    bar_cmd_reg u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (wr_cmd),
        .be_lo    (cfg_be[0]),
        .wdata_lo (cfg_wdata[1:0]),
        .en       (en)
    );

    bar_base_reg #(.SIZE_LOG2(SIZE_LOG2)) u_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (wr_bar),
        .be     (cfg_be),
        .wdata  (cfg_wdata),
        .base   (base)
    );

    bar_decode #(.SIZE_LOG2(SIZE_LOG2), .IS_IO(IS_IO)) u_dec (
        .base        (base),
        .en          (en),
        .slot_absent (slot_absent),
        .bus_valid   (bus_valid),
        .bus_is_io   (bus_is_io),
        .bus_addr    (bus_addr),
        .bus_hit     (bus_hit)
    );

    // Select configuration read data by offset, all ones for an empty slot.
    always_comb begin
        if (slot_absent) begin
            cfg_rdata = 32'hFFFF_FFFF;
        end else if (cfg_addr == ADDR_W'(OFF_ID)) begin
            cfg_rdata = {DEVICE_ID, VENDOR_ID};
        end else if (cfg_addr == ADDR_W'(OFF_CMD)) begin
            cfg_rdata = {30'h0, en.mem_en, en.io_en};
        end else if (cfg_addr == ADDR_W'(OFF_BAR)) begin
            cfg_rdata = base | TYPE_BITS;
        end else begin
            cfg_rdata = 32'h0;
        end
    end
endmodule

// File: rtl/bar_sizing_chk.sv
// Property checker for bar_sizing_top, attached by bind.
// Assumes the bound parameters match the target instance.
module bar_sizing_chk
    import bar_pkg::*;
#(
    parameter int SIZE_LOG2 = 12,
    parameter bit IS_IO     = 1'b0,
    parameter int ADDR_W    = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_absent,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              cfg_wr_en,
    input logic [31:0]       cfg_rdata,
    input logic              bus_is_io,
    input logic              bus_hit,
    input logic              io_en,
    input logic              mem_en,
    input logic [31:0]       base
);
    localparam logic [31:0] LOWMASK = ~(32'hFFFF_FFFF << SIZE_LOG2) & 32'hFFFF_FFFE;

    logic bar_rd;
    logic bar_wr;
    always_comb begin
        bar_rd = !slot_absent && (cfg_addr == ADDR_W'(OFF_BAR));
        bar_wr = cfg_wr_en && bar_rd;
    end

    AST_TYPE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        bar_rd |-> (cfg_rdata[0] == IS_IO)); // R2
    AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bar_rd |-> ((cfg_rdata & LOWMASK) == 32'h0)); // R3
    AST_ABSENT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        slot_absent |-> (cfg_rdata == 32'hFFFF_FFFF)); // R9
    AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        slot_absent |-> !bus_hit); // R9
    AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hit |-> (bus_is_io ? io_en : mem_en)); // R7
    AST_HIT_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hit |-> (bus_is_io == IS_IO)); // R8
    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bar_wr |=> $stable(base)); // R4
    AST_EN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!io_en && !mem_en)); // R1
endmodule

bind bar_sizing_top bar_sizing_chk #(
    .SIZE_LOG2 (SIZE_LOG2),
    .IS_IO     (IS_IO),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_absent (slot_absent),
    .cfg_addr    (cfg_addr),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_rdata   (cfg_rdata),
    .bus_is_io   (bus_is_io),
    .bus_hit     (bus_hit),
    .io_en       (en.io_en),
    .mem_en      (en.mem_en),
    .base        (base)
);

// File: tb/sim_bar_sizing_top.sv
`timescale 1ns/1ps
// Bench: a memory instance (u0, 4 KiB) and an I/O instance (u1, 256 B)
// share one stimulus; a behavioural model is compared on every falling edge.
module sim_bar_sizing_top;
    localparam int          AW  = 6;
    localparam logic [15:0] VEN = 16'h1F2E;
    localparam logic [15:0] DEV = 16'h0A5C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slot_absent = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic          cfg_wr_en = 1'b0;
    logic [3:0]    cfg_be = 4'h0;
    logic [31:0]   cfg_wdata = '0;
    logic          bus_valid = 1'b0;
    logic          bus_is_io = 1'b0;
    logic [31:0]   bus_addr = '0;
    logic [31:0]   rd0, rd1;
    logic          hit0, hit1;

    int n_cmp = 0;
    int n_bad = 0;

    // Model state per instance
    int unsigned m_base [2];
    bit          m_io   [2];
    bit          m_mem  [2];
    int          m_log2 [2] = '{12, 8};
    bit          m_isio [2] = '{1'b0, 1'b1};

    always #2.5 clk = ~clk;

    bar_sizing_top #(.SIZE_LOG2(12), .IS_IO(1'b0), .ADDR_W(AW),
                     .VENDOR_ID(VEN), .DEVICE_ID(DEV)) u0 (
        .clk(clk), .rst_n(rst_n), .slot_absent(slot_absent),
        .cfg_addr(cfg_addr), .cfg_wr_en(cfg_wr_en), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd0), .bus_valid(bus_valid),
        .bus_is_io(bus_is_io), .bus_addr(bus_addr), .bus_hit(hit0));

    bar_sizing_top #(.SIZE_LOG2(8), .IS_IO(1'b1), .ADDR_W(AW),
                     .VENDOR_ID(VEN), .DEVICE_ID(DEV)) u1 (
        .clk(clk), .rst_n(rst_n), .slot_absent(slot_absent),
        .cfg_addr(cfg_addr), .cfg_wr_en(cfg_wr_en), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd1), .bus_valid(bus_valid),
        .bus_is_io(bus_is_io), .bus_addr(bus_addr), .bus_hit(hit1));

    function automatic logic [31:0] exp_rd(int i);
        if (slot_absent) return 32'hFFFF_FFFF;
        case (int'(cfg_addr))
            0: return {DEV, VEN};
            1: return {30'h0, m_mem[i], m_io[i]};
            4: return m_base[i] | (m_isio[i] ? 32'h1 : 32'h0);
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_hit(int i);
        bit en_ok;
        en_ok = m_isio[i] ? m_io[i] : m_mem[i];
        return bus_valid && !slot_absent && (bus_is_io == m_isio[i]) && en_ok
               && (((bus_addr ^ m_base[i]) >> m_log2[i]) == 0);
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Compare both instances against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("model R10 R11 read u0", rd0, exp_rd(0));
            check("model R10 R11 read u1", rd1, exp_rd(1));
            check("model R8 hit u0", {31'h0, hit0}, {31'h0, exp_hit(0)});
            check("model R8 hit u1", {31'h0, hit1}, {31'h0, exp_hit(1)});
        end
    end

    // Apply a model write for one instance.
    task automatic model_wr(int i, int off, logic [3:0] be, logic [31:0] d);
        logic [31:0] v;
        if (slot_absent) return;
        if (off == 1 && be[0]) begin
            m_io[i]  = d[0];
            m_mem[i] = d[1];
        end else if (off == 4) begin
            v = m_base[i];
            for (int b = 0; b < 4; b++)
                if (be[b]) v[b*8 +: 8] = d[b*8 +: 8];
            m_base[i] = v & (32'hFFFF_FFFF << m_log2[i]);
        end
    endtask

    task automatic cfg_write(int off, logic [3:0] be, logic [31:0] d);
        @(posedge clk); #1;
        cfg_addr = AW'(off); cfg_be = be; cfg_wdata = d; cfg_wr_en = 1'b1;
        @(posedge clk); #1;
        model_wr(0, off, be, d);
        model_wr(1, off, be, d);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd_check(string req, int off, logic [31:0] e0, logic [31:0] e1);
        @(posedge clk); #1;
        cfg_addr = AW'(off);
        @(negedge clk);
        check({req, " u0"}, rd0, e0);
        check({req, " u1"}, rd1, e1);
    endtask

    task automatic bus_check(string req, logic io, logic [31:0] a, logic e0, logic e1);
        @(posedge clk); #1;
        bus_valid = 1'b1; bus_is_io = io; bus_addr = a;
        @(negedge clk);
        check({req, " u0"}, {31'h0, hit0}, {31'h0, e0});
        check({req, " u1"}, {31'h0, hit1}, {31'h0, e1});
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_base = '{0, 0}; m_io = '{0, 0}; m_mem = '{0, 0};
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        rd_check("R1 reset base", 4, 32'h0, 32'h1);
        rd_check("R1 reset cmd", 1, 32'h0, 32'h0);
        bus_check("R1 reset no hit", 1'b0, 32'h0000_0010, 1'b0, 1'b0);
        bus_check("R1 reset no hit io", 1'b1, 32'h0000_0010, 1'b0, 1'b0);
        rd_check("R10 id", 0, {DEV, VEN}, {DEV, VEN});

        cfg_write(4, 4'hF, 32'hFFFF_FFFF);
        rd_check("R3 sizing", 4, 32'hFFFF_F000, 32'hFFFF_FF01);
        cfg_write(4, 4'hF, 32'h0000_0000);
        rd_check("R2 type bit held", 4, 32'h0, 32'h1);
        cfg_write(4, 4'hF, 32'h1234_5678);
        rd_check("R4 aligned base", 4, 32'h1234_5000, 32'h1234_5601);
        cfg_write(4, 4'b0100, 32'hAABB_CCDD);
        rd_check("R5 byte lane", 4, 32'h12BB_5000, 32'h12BB_5601);

        cfg_write(4, 4'hF, 32'h4000_0000);
        bus_check("R7 disabled mem", 1'b0, 32'h4000_0010, 1'b0, 1'b0);
        bus_check("R7 disabled io", 1'b1, 32'h4000_0010, 1'b0, 1'b0);
        cfg_write(1, 4'h1, 32'h0000_0003);
        rd_check("R6 cmd readback", 1, 32'h3, 32'h3);
        bus_check("R8 mem inside", 1'b0, 32'h4000_0010, 1'b1, 1'b0);
        bus_check("R8 io inside", 1'b1, 32'h4000_0010, 1'b0, 1'b1);
        bus_check("R8 mem top edge", 1'b0, 32'h4000_0FFF, 1'b1, 1'b0);
        bus_check("R8 mem past top", 1'b0, 32'h4000_1000, 1'b0, 1'b0);
        bus_check("R8 mem below", 1'b0, 32'h3FFF_FFFF, 1'b0, 1'b0);
        bus_check("R8 io top edge", 1'b1, 32'h4000_00FF, 1'b0, 1'b1);
        bus_check("R8 io past top", 1'b1, 32'h4000_0100, 1'b0, 1'b0);
        @(posedge clk); #1 bus_valid = 1'b0;
        @(negedge clk);
        check("R8 not valid u0", {31'h0, hit0}, 32'h0);

        cfg_write(1, 4'h1, 32'h0000_0001);
        bus_check("R7 mem off", 1'b0, 32'h4000_0010, 1'b0, 1'b0);
        bus_check("R7 io still on", 1'b1, 32'h4000_0010, 1'b0, 1'b1);
        cfg_write(1, 4'h0, 32'h0000_0000);
        rd_check("R5 R6 cmd no lane", 1, 32'h1, 32'h1);
        rd_check("R11 unused offset", 2, 32'h0, 32'h0);

        @(posedge clk); #1 slot_absent = 1'b1;
        rd_check("R9 absent id", 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd_check("R9 absent base", 4, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        bus_check("R9 absent no hit", 1'b1, 32'h4000_0010, 1'b0, 1'b0);
        cfg_write(4, 4'hF, 32'h8000_0000);
        @(posedge clk); #1 slot_absent = 1'b0;
        rd_check("R9 write ignored", 4, 32'h4000_0000, 32'h4000_0001);

        repeat (2) @(posedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule